// File: doc/BRIEF.md
# Weightless N-Tuple Pattern Classifier

This block sorts binary images into classes without any multipliers or stored weights. Every class is a bank of small one-bit lookup memories. An incoming frame of 1-bit pixels is scattered through a fixed pseudo-random map into K tuples of N pixels. Each tuple forms an N-bit address into its own one-bit memory, and each class has a separate copy of every such memory.

Frames arrive one pixel per valid cycle, and a start marker flags the first pixel. After the last pixel the block sweeps the K tuples, one per cycle. In training mode it sets the addressed bit of the selected class. In recall mode it only reads. In both modes it counts, for every class, how many tuples hit a stored 1. It then raises a one-cycle result strobe with every class score and the index of the best class. A separate clear input wipes all classes at once.

Top module: `ntd_classifier`

## Requirements
- R1: After reset, res_valid is low, res_scores and res_best are zero, and every memory bit of every class is 0, so a first recall scores 0 for all classes.
- R2: Counting pixels of a frame from 0 at the start marker, pixel p is placed at position q = (p*MUL + OFS) mod (K*N) with MUL=37 and OFS=11 by default. Tuple t takes positions t*N to t*N+N-1 as its address, with position t*N as the address LSB.
- R3: In recall mode, the score of class c is the number of tuples t whose memory in class c holds 1 at the address of tuple t.
- R4: A training frame sets to 1 the addressed bit of every tuple memory of the selected class. It leaves every other bit of every class as it was and never clears a bit.
- R5: A training frame also produces a result strobe. Its scores are those the memories gave before that frame's writes.
- R6: A one-cycle clear_all pulse zeros every memory bit of every class and abandons any frame in progress. Pixels that follow without a new start marker are ignored.
- R7: res_best is the index of the highest score. On a tie it is the lowest of the tied class indices.
- R8: res_valid is a single-cycle pulse. It is high in the cycle after the (K+1)th rising edge that follows the edge accepting the last pixel. res_scores and res_best hold their values until the next pulse.
- R9: Pixels with pix_valid low are ignored, as are valid pixels before any start marker. A start marker in the middle of a frame restarts the pixel count at 0.
- R10: Pixels, start markers included, that arrive while a frame is being swept or reported are ignored.
- R11: The score of class c sits at res_scores[c*SW +: SW] with SW = clog2(K+1), and is never above K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Zero all class memories and abandon any frame |
| train_en | input | 1 | Sampled with the start marker: 1 trains, 0 recalls |
| train_cls | input | clog2(NCLS) | Class to train, sampled with the start marker |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_bit | input | 1 | Binarised pixel value |
| res_valid | output | 1 | One-cycle result strobe |
| res_scores | output | NCLS*SW | Per-class hit counts, class 0 in the low bits |
| res_best | output | clog2(NCLS) | Index of the highest score, lowest index on a tie |

## Verification
The bench uses the default build: 4 classes, 16 tuples of 4 pixels, a 64-pixel frame and the default scatter constants. Scores then span 0 to 16 in a 5-bit field, and the bench can keep a full model of the 1024 memory bits. At this size, exact ties between trained classes are easy to create, as are full-score matches and single-pixel perturbations. Random trained and noisy frames are mixed with gaps in the pixel stream, stray pixels during the sweep, restarted frames and clears in mid-frame.

// File: rtl/ntd_pkg.sv
package ntd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RES  = 2'd2
  } ntd_state_e;

  // Fixed scatter map: arrival index -> image position.
  // Bijective when pix is a power of two and mul is odd.
  function automatic int unsigned scatter_pos(input int unsigned p,
                                              input int unsigned pix,
                                              input int unsigned mul,
                                              input int unsigned ofs);
    return (p * mul + ofs) % pix;
  endfunction

  function automatic int unsigned width_of(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/ntd_frame_in.sv
module ntd_frame_in
  import ntd_pkg::*;
#(
  parameter int unsigned PIX = 64,
  parameter int unsigned MUL = 37,
  parameter int unsigned OFS = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort,
  input  logic           hold,
  input  logic           pix_valid,
  input  logic           pix_sof,
  input  logic           pix_bit,
  output logic [PIX-1:0] img,
  output logic           frm_start,
  output logic           frm_last
);

  localparam int unsigned CW = width_of(PIX);

  logic [CW-1:0] cnt;
  logic          collecting;
  logic          take;
  logic [CW-1:0] pidx;
  logic [CW-1:0] wpos;

  always_comb begin
    take      = pix_valid && !hold && !abort && (pix_sof || collecting);
    pidx      = pix_sof ? '0 : cnt;
    wpos      = CW'(scatter_pos(32'(pidx), PIX, MUL, OFS));
    frm_start = take && pix_sof;
    frm_last  = take && (pidx == CW'(PIX - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      collecting <= 1'b0;
      img        <= '0;
    end else if (abort) begin
      cnt        <= '0;
      collecting <= 1'b0;
    end else if (take) begin
      img[wpos] <= pix_bit;
      if (frm_last) begin
        cnt        <= '0;
        collecting <= 1'b0;
      end else begin
        cnt        <= pidx + CW'(1);
        collecting <= 1'b1;
      end
    end
  end

  // R9
  mid_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !frm_last && !abort) |=> (cnt == CW'(1) && collecting));

  // R6
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !collecting);

endmodule

// File: rtl/ntd_class_ram.sv
module ntd_class_ram
  import ntd_pkg::*;
#(
  parameter int unsigned K = 16,
  parameter int unsigned N = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [width_of(K)-1:0] rd_tuple,
  input  logic [N-1:0]           rd_addr,
  input  logic                   wr_en,
  output logic                   hit
);

  localparam int unsigned DEPTH = 2 ** N;
  localparam int unsigned BITS  = K * DEPTH;
  localparam int unsigned IW    = width_of(BITS);

  logic [BITS-1:0] mem;
  logic [IW-1:0]   idx;

  always_comb begin
    idx = IW'(int'(rd_tuple) * DEPTH + int'(rd_addr));
    hit = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (clr) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[idx] <= 1'b1;
    end
  end

  // R4
  wr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mem[$past(idx)]);

  // R4
  bits_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((mem & $past(mem)) == $past(mem)));

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mem == '0));

endmodule

// File: rtl/ntd_argmax.sv
module ntd_argmax #(
  parameter int unsigned NCLS = 4,
  parameter int unsigned SW   = 5,
  parameter int unsigned CLW  = 2
) (
  input  logic [NCLS*SW-1:0] scores,
  output logic [CLW-1:0]     best
);

  logic [SW-1:0] top;

  // Strict greater-than keeps the lowest index on ties.
  always_comb begin
    best = '0;
    top  = scores[0 +: SW];
    for (int c = 1; c < int'(NCLS); c++) begin
      if (scores[c*SW +: SW] > top) begin
        top  = scores[c*SW +: SW];
        best = CLW'(c);
      end
    end
  end

endmodule

// File: rtl/ntd_classifier.sv
module ntd_classifier
  import ntd_pkg::*;
#(
  parameter int unsigned NCLS = 4,
  parameter int unsigned K    = 16,
  parameter int unsigned N    = 4,
  parameter int unsigned MUL  = 37,
  parameter int unsigned OFS  = 11,
  localparam int unsigned SW  = $clog2(K + 1),
  localparam int unsigned CLW = width_of(NCLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_all,
  input  logic               train_en,
  input  logic [CLW-1:0]     train_cls,
  input  logic               pix_valid,
  input  logic               pix_sof,
  input  logic               pix_bit,
  output logic               res_valid,
  output logic [NCLS*SW-1:0] res_scores,
  output logic [CLW-1:0]     res_best
);

  localparam int unsigned PIX = K * N;
  localparam int unsigned TW  = width_of(K);

  ntd_state_e        state;
  logic [TW-1:0]     tidx;
  logic              trn_q;
  logic [CLW-1:0]    cls_q;
  logic [NCLS*SW-1:0] acc;
  logic [NCLS-1:0]   hit;
  logic [NCLS-1:0]   wr;
  logic [PIX-1:0]    img;
  logic [N-1:0]      taddr;
  logic [CLW-1:0]    pick;
  logic              frm_start;
  logic              frm_last;
  logic              busy;
  logic              scan_end;

  always_comb begin
    busy     = (state != ST_IDLE);
    taddr    = img[int'(tidx)*N +: N];
    scan_end = (state == ST_SCAN) && (tidx == TW'(K - 1));
  end

  ntd_frame_in #(.PIX(PIX), .MUL(MUL), .OFS(OFS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (clear_all),
    .hold      (busy),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_bit   (pix_bit),
    .img       (img),
    .frm_start (frm_start),
    .frm_last  (frm_last)
  );

  for (genvar c = 0; c < int'(NCLS); c++) begin : g_cls
    assign wr[c] = (state == ST_SCAN) && trn_q && (cls_q == CLW'(c));

    ntd_class_ram #(.K(K), .N(N)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clear_all),
      .rd_tuple (tidx),
      .rd_addr  (taddr),
      .wr_en    (wr[c]),
      .hit      (hit[c])
    );
  end

  ntd_argmax #(.NCLS(NCLS), .SW(SW), .CLW(CLW)) u_pick (
    .scores (acc),
    .best   (pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tidx       <= '0;
      trn_q      <= 1'b0;
      cls_q      <= '0;
      acc        <= '0;
      res_valid  <= 1'b0;
      res_scores <= '0;
      res_best   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (clear_all) begin
        state <= ST_IDLE;
        tidx  <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (frm_start) begin
              trn_q <= train_en;
              cls_q <= train_cls;
            end
            if (frm_last) begin
              state <= ST_SCAN;
              tidx  <= '0;
              acc   <= '0;
            end
          end
          ST_SCAN: begin
            for (int c = 0; c < int'(NCLS); c++) begin
              acc[c*SW +: SW] <= acc[c*SW +: SW] + SW'(hit[c]);
            end
            tidx <= tidx + TW'(1);
            if (scan_end) state <= ST_RES;
          end
          ST_RES: begin
            res_valid  <= 1'b1;
            res_scores <= acc;
            res_best   <= pick;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_scores) && $stable(res_best)));

  // R10
  no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!frm_start && !frm_last));

  for (genvar c = 0; c < int'(NCLS); c++) begin : g_chk
    // R7
    best_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_scores[int'(res_best)*SW +: SW] >= res_scores[c*SW +: SW]));

    // R7
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (CLW'(c) < res_best)) |->
        (res_scores[int'(res_best)*SW +: SW] > res_scores[c*SW +: SW]));

    // R11
    score_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_scores[c*SW +: SW] <= SW'(K)));
  end

endmodule

// File: tb/ntd_classifier_tb.sv
module ntd_classifier_tb;

  localparam int NC = 4;
  localparam int KT = 16;
  localparam int NT = 4;
  localparam int PX = KT * NT;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_all = 1'b0;
  logic train_en = 1'b0;
  logic [1:0] train_cls = '0;
  logic pix_valid = 1'b0;
  logic pix_sof = 1'b0;
  logic pix_bit = 1'b0;
  logic res_valid;
  logic [NC*SW-1:0] res_scores;
  logic [1:0] res_best;

  int total = 0;
  int bad = 0;

  logic [15:0] mdl [NC][KT];
  logic [NC*SW-1:0] last_sc;
  int last_best;

  always #10 clk = ~clk;

  ntd_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .train_en(train_en), .train_cls(train_cls),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_bit(pix_bit),
    .res_valid(res_valid), .res_scores(res_scores), .res_best(res_best)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Arrival index -> position, restated from R2.
  function automatic int place(input int p);
    return (p * 37 + 11) % PX;
  endfunction

  function automatic logic [3:0] tuple_addr(input logic [PX-1:0] f, input int t);
    logic [PX-1:0] im;
    im = '0;
    for (int p = 0; p < PX; p++) im[place(p)] = f[p];
    return im[t*NT +: NT];
  endfunction

  function automatic int exp_score(input logic [PX-1:0] f, input int c);
    int s;
    s = 0;
    for (int t = 0; t < KT; t++) if (mdl[c][t][tuple_addr(f, t)]) s++;
    return s;
  endfunction

  function automatic int exp_best(input logic [PX-1:0] f);
    int b;
    int top;
    b = 0;
    top = exp_score(f, 0);
    for (int c = 1; c < NC; c++) begin
      if (exp_score(f, c) > top) begin
        top = exp_score(f, c);
        b = c;
      end
    end
    return b;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < KT; t++) mdl[c][t] = '0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    model_clear();
  endtask

  task automatic send_pixels(input logic [PX-1:0] f, input int cnt, input bit first_sof);
    for (int p = 0; p < cnt; p++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_sof = first_sof && (p == 0);
      pix_bit = f[p];
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_sof = 1'b0;
  endtask

  task automatic do_frame(input logic [PX-1:0] f, input bit trn, input int cls,
                          input bit gaps, input bit tail, input string req);
    int esc [NC];
    int eb;
    int lat;
    bit got;
    for (int c = 0; c < NC; c++) esc[c] = exp_score(f, c);
    eb = exp_best(f);
    for (int p = 0; p < PX; p++) begin
      if (gaps) begin
        while ($urandom % 4 == 0) begin
          @(negedge clk);
          pix_valid = 1'b0;
          pix_sof = 1'b0;
          pix_bit = 1'($urandom);
        end
      end
      @(negedge clk);
      pix_valid = 1'b1;
      pix_sof = (p == 0);
      pix_bit = f[p];
      train_en = trn;
      train_cls = 2'(cls);
    end
    @(posedge clk);
    lat = 0;
    got = 1'b0;
    while (!got && lat < 4 * KT) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (res_valid) begin
        got = 1'b1;
      end else if (tail && lat < 6) begin
        pix_valid = 1'b1;
        pix_sof = (lat == 1);
        pix_bit = 1'($urandom);
      end else begin
        pix_valid = 1'b0;
        pix_sof = 1'b0;
      end
    end
    pix_valid = 1'b0;
    pix_sof = 1'b0;
    // R8 latency
    chk(got && lat == KT + 1, "R8 latency", lat, KT + 1);
    for (int c = 0; c < NC; c++)
      chk(int'(res_scores[c*SW +: SW]) == esc[c], req, int'(res_scores[c*SW +: SW]), esc[c]);
    // R7 best class
    chk(int'(res_best) == eb, "R7 best", int'(res_best), eb);
    last_sc = res_scores;
    last_best = int'(res_best);
    if (trn)
      for (int t = 0; t < KT; t++) mdl[cls][t][tuple_addr(f, t)] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PX-1:0] fa, fb, fr;
    logic [PX-1:0] protos [NC];
    int p5, q;
    bit seen;
    void'($urandom(32'd2024));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
    chk(res_scores == '0, "R1 scores", int'(res_scores), 0);
    chk(res_best == '0, "R1 best", int'(res_best), 0);

    // R9 pixels before any start marker are ignored
    fr = {$urandom, $urandom};
    send_pixels(fr, PX, 1'b0);
    repeat (KT + 4) @(negedge clk);
    chk(res_valid == 1'b0 && res_scores == '0, "R9 no sof", int'(res_valid), 0);

    // R1 empty memories score zero, tie goes to class 0
    do_frame({$urandom, $urandom}, 1'b0, 0, 1'b0, 1'b0, "R1 empty recall");

    // R4 R5 training class 2 reports pre-write scores
    fa = {$urandom, $urandom};
    do_frame(fa, 1'b1, 2, 1'b0, 1'b0, "R5 train prewrite");
    // R3 recall of the trained frame
    do_frame(fa, 1'b0, 0, 1'b0, 1'b0, "R3 recall match");
    chk(last_best == 2, "R3 best after train", last_best, 2);

    // R7 tie between classes 1 and 3
    fb = {$urandom, $urandom};
    do_frame(fb, 1'b1, 3, 1'b0, 1'b0, "R4 train c3");
    do_frame(fb, 1'b1, 1, 1'b0, 1'b0, "R4 train c1");
    do_frame(fb, 1'b0, 0, 1'b0, 1'b0, "R7 tie recall");
    chk(last_best == 1, "R7 tie low index", last_best, 1);

    // R8 hold after the strobe
    repeat (5) @(negedge clk);
    chk(res_scores == last_sc && int'(res_best) == last_best, "R8 hold",
        int'(res_scores), int'(last_sc));

    // R10 stray pixels during the sweep
    do_frame(fa, 1'b0, 0, 1'b0, 1'b1, "R10 tail ignored");

    // R9 mid-frame restart
    send_pixels({$urandom, $urandom}, 20, 1'b1);
    do_frame(fb, 1'b0, 0, 1'b1, 1'b0, "R9 restart");

    // R2 scatter map, single-pixel probes
    do_clear();
    do_frame('0, 1'b1, 0, 1'b0, 1'b0, "R2 train zero");
    p5 = 5;
    do_frame(PX'(1) << p5, 1'b1, 1, 1'b0, 1'b0, "R2 train one pixel");
    do_frame(PX'(1) << p5, 1'b0, 0, 1'b0, 1'b0, "R2 probe same");
    q = 0;
    for (int p = 0; p < PX; p++)
      if (p != p5 && place(p) / NT == place(p5) / NT) q = p;
    do_frame(PX'(1) << q, 1'b0, 0, 1'b0, 1'b0, "R2 probe same tuple");
    chk(int'(last_sc[1*SW +: SW]) == KT - 1, "R2 neighbour bit", int'(last_sc[1*SW +: SW]), KT - 1);

    // R6 clear in mid-frame, remainder ignored, memories zero
    fr = {$urandom, $urandom};
    send_pixels(fr, 30, 1'b1);
    @(negedge clk);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    model_clear();
    seen = 1'b0;
    for (int p = 0; p < 34 + KT + 4; p++) begin
      @(negedge clk);
      if (res_valid) seen = 1'b1;
      pix_valid = (p < 34);
      pix_bit = 1'($urandom);
      pix_sof = 1'b0;
    end
    pix_valid = 1'b0;
    chk(!seen, "R6 abandon frame", int'(seen), 0);
    do_frame(fr, 1'b0, 0, 1'b0, 1'b0, "R6 cleared recall");

    // R3 R4 R11 random training and noisy recall
    for (int c = 0; c < NC; c++) protos[c] = {$urandom, $urandom};
    for (int i = 0; i < 40; i++) begin
      int c;
      logic [PX-1:0] f;
      c = int'($urandom % NC);
      f = protos[c];
      for (int k = 0; k < int'($urandom % 6); k++) f[$urandom % PX] ^= 1'b1;
      if ($urandom % 3 == 0)
        do_frame(f, 1'b1, c, 1'($urandom), 1'($urandom), "R4 random train");
      else
        do_frame(f, 1'b0, 0, 1'($urandom), 1'($urandom), "R3 R11 random recall");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule